// File: doc/BRIEF.md
# Core Store Queue with Load Forwarding

This block sits between the store execution stage and the cache write port of one core. An executed store is written into a small circular queue along with its address, data and byte-enable mask. At that point it is still speculative. The retire pulse from the commit stage promotes the oldest speculative entry to retired. Only retired entries are offered to memory. They leave strictly oldest first, at most one per cycle, whenever the memory side is ready. When the memory side is slow, execution continues to fill the queue until it is full.

A mis-speculation flush throws away every entry that has not retired. Retired entries are kept because they are already architecturally committed. Loads from the same core look into the queue in the same cycle. The youngest entry whose bytes overlap the load either supplies the data or, when it covers only part of the load, tells the load stage to stall. In this way the core sees its own stores before any other agent can.

Top module: `store_buffer`

## Requirements
- R1: After reset the queue is empty: `st_full`, `mem_valid`, `ld_hit` and `ld_stall` are all 0.
- R2: A store offered on `st_valid` is accepted when `st_full` is 0. `st_full` is 1 while 8 entries are held. A store offered while full is dropped and leaves no trace for later loads.
- R3: A store is never offered on the memory port before it retires. Each `retire_valid` cycle promotes the oldest speculative entry, one per cycle. The pulse is ignored when no speculative entry exists.
- R4: Retired stores are offered on `mem_valid` oldest first. One leaves per cycle in which `mem_valid` and `mem_ready` are both 1. While `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_mask` stay unchanged.
- R5: `flush` removes every speculative entry, including a store offered in the same cycle. Retired entries survive. A retire pulse in the flush cycle takes effect first, so that entry survives too.
- R6: A load matches entries by word address, ignoring address bits [1:0]. Only the youngest held entry whose mask shares a byte with `ld_mask` is considered. Mask bit i selects data bits [8i+7:8i]. If that entry covers every byte of `ld_mask`, `ld_hit` is 1 and `ld_data` holds its bytes selected by `ld_mask`, with the other bytes zero.
- R7: If that youngest overlapping entry covers only some of the load's bytes, `ld_stall` is 1 and `ld_hit` is 0.
- R8: With no overlapping entry, both `ld_hit` and `ld_stall` are 0 and `ld_data` is zero.
- R9: Speculative and retired entries forward alike. An entry that has drained to memory no longer forwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store issue request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_mask | input | 4 | Store byte enables |
| st_full | output | 1 | Queue full, store issue must stall |
| retire_valid | input | 1 | Oldest speculative store has retired |
| flush | input | 1 | Mis-speculation, drop speculative stores |
| mem_valid | output | 1 | A retired store is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | 32 | Address of the offered store |
| mem_data | output | 32 | Data of the offered store |
| mem_mask | output | 4 | Byte enables of the offered store |
| ld_addr | input | 32 | Load byte address |
| ld_mask | input | 4 | Load byte enables |
| ld_hit | output | 1 | Load fully served by a queued store |
| ld_stall | output | 1 | Load partially overlaps the youngest matching store |
| ld_data | output | 32 | Forwarded load data |

## Verification
Retirement and flush can arrive in the same cycle. The bench provokes this while the queue is full: one cycle carries `retire_valid` and `flush` together. It then judges the result at the ports. `st_full` must fall. A load to the first store's address must still hit. A load to the second store's address must miss. The memory port must offer the surviving store. A second collision, between an offered store and a flush, is judged by a load to that store's address, which must miss.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_DATA_W = 32;
  localparam int SB_MASK_W = SB_DATA_W / 8;

  typedef logic [SB_MASK_W-1:0] bmask_t;
  typedef logic [SB_DATA_W-1:0] word_t;

  // distance of a slot from the head, going toward younger entries
  function automatic int ring_dist(input int slot, input int head, input int depth);
    return (slot >= head) ? (slot - head) : (slot + depth - head);
  endfunction

  // a store mask serves a load only if it has every byte the load wants
  function automatic logic mask_covers(input bmask_t st_m, input bmask_t ld_m);
    return (st_m & ld_m) == ld_m;
  endfunction

  function automatic word_t mask_to_bits(input bmask_t m);
    word_t w;
    for (int b = 0; b < SB_MASK_W; b++) w[8*b +: 8] = {8{m[b]}};
    return w;
  endfunction
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          retire_req,
  input  logic          flush,
  input  logic          mem_ready,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] ret_occ,
  output logic [DEPTH-1:0] valid_vec
);
  logic [IW-1:0] head_q, tail_q, head_n, tail_n;
  logic [CW-1:0] occ_q, ret_q, occ_n, ret_n;
  logic          ret_ok;

  assign full    = (occ_q == CW'(DEPTH));
  assign pop_ok  = (ret_q != '0) && mem_ready;
  assign ret_ok  = retire_req && (ret_q < occ_q);
  assign push_ok = push_req && !full && !flush;

  always_comb begin
    ret_n  = ret_q + CW'(ret_ok) - CW'(pop_ok);
    head_n = pop_ok ? IW'((int'(head_q) + 1) % DEPTH) : head_q;
    if (flush) begin
      occ_n  = ret_n;
      tail_n = IW'((int'(head_n) + int'(ret_n)) % DEPTH);
    end else begin
      occ_n  = occ_q + CW'(push_ok) - CW'(pop_ok);
      tail_n = push_ok ? IW'((int'(tail_q) + 1) % DEPTH) : tail_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      ret_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      occ_q  <= occ_n;
      ret_q  <= ret_n;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_valid
      assign valid_vec[i] = sb_pkg::ring_dist(i, int'(head_q), DEPTH) < int'(occ_q);
    end
  endgenerate

  assign head    = head_q;
  assign tail    = tail_q;
  assign occ     = occ_q;
  assign ret_occ = ret_q;
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IW    = $clog2(DEPTH),
  localparam int OFF_W = $clog2(SB_MASK_W)
) (
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  word_t             ent_data [DEPTH],
  input  bmask_t            ent_mask [DEPTH],
  input  logic [DEPTH-1:0]  valid_vec,
  input  logic [IW-1:0]     head,
  input  logic [ADDR_W-1:0] ld_addr,
  input  bmask_t            ld_mask,
  output logic              hit,
  output logic              stall,
  output word_t             data
);
  logic          found;
  logic [IW-1:0] sel;

  // scan oldest to youngest; the last overlapping entry wins
  always_comb begin
    logic [IW-1:0]     slot;
    logic [ADDR_W-1:0] diff;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = IW'((int'(head) + k) % DEPTH);
      diff = ent_addr[slot] ^ ld_addr;
      if (valid_vec[slot] && ((diff >> OFF_W) == '0) && ((ent_mask[slot] & ld_mask) != '0)) begin
        found = 1'b1;
        sel   = slot;
      end
    end
  end

  assign hit   = found && mask_covers(ent_mask[sel], ld_mask);
  assign stall = found && !mask_covers(ent_mask[sel], ld_mask);
  assign data  = hit ? (ent_data[sel] & mask_to_bits(ld_mask)) : '0;
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SB_DATA_W-1:0] st_data,
  input  logic [SB_MASK_W-1:0] st_mask,
  output logic              st_full,
  input  logic              retire_valid,
  input  logic              flush,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SB_DATA_W-1:0] mem_data,
  output logic [SB_MASK_W-1:0] mem_mask,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SB_MASK_W-1:0] ld_mask,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic [SB_DATA_W-1:0] ld_data
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  word_t             data_q [DEPTH];
  bmask_t            mask_q [DEPTH];

  // named internal events for the checker
  logic              push_ok, pop_ok;
  logic [IW-1:0]     head, tail;
  logic [CW-1:0]     occ, ret_occ;
  logic [DEPTH-1:0]  valid_vec;

  sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (st_valid),
    .retire_req(retire_valid),
    .flush     (flush),
    .mem_ready (mem_ready),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .full      (st_full),
    .head      (head),
    .tail      (tail),
    .occ       (occ),
    .ret_occ   (ret_occ),
    .valid_vec (valid_vec)
  );

  always_ff @(posedge clk) begin
    if (push_ok) begin
      addr_q[tail] <= st_addr;
      data_q[tail] <= st_data;
      mask_q[tail] <= st_mask;
    end
  end

  assign mem_valid = (ret_occ != '0);
  assign mem_addr  = addr_q[head];
  assign mem_data  = data_q[head];
  assign mem_mask  = mask_q[head];

  sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fwd (
    .ent_addr (addr_q),
    .ent_data (data_q),
    .ent_mask (mask_q),
    .valid_vec(valid_vec),
    .head     (head),
    .ld_addr  (ld_addr),
    .ld_mask  (ld_mask),
    .hit      (ld_hit),
    .stall    (ld_stall),
    .data     (ld_data)
  );
endmodule

// File: rtl/store_buffer_chk.sv
module store_buffer_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_full,
  input logic              flush,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic [3:0]        mem_mask,
  input logic              ld_hit,
  input logic              ld_stall,
  input logic              pop_ok,
  input logic [CW-1:0]     occ,
  input logic [CW-1:0]     ret_occ
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(occ) <= DEPTH); // R2
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    st_full && st_valid && !pop_ok && !flush |=> occ == $past(occ)); // R2
  AST_RETIRED_WITHIN: assert property (@(posedge clk) disable iff (!rst_n) ret_occ <= occ); // R3
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_mask)); // R4
  AST_FLUSH_TRIMS: assert property (@(posedge clk) disable iff (!rst_n) flush |=> occ == ret_occ); // R5
  AST_FLUSH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !pop_ok |=> ret_occ >= $past(ret_occ)); // R5
  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ld_hit && ld_stall)); // R7
endmodule

bind store_buffer store_buffer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_full(st_full), .flush(flush),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_mask(mem_mask), .ld_hit(ld_hit), .ld_stall(ld_stall), .pop_ok(pop_ok),
  .occ(occ), .ret_occ(ret_occ)
);

// File: tb/store_buffer_bench.sv
module store_buffer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, st_valid, st_full, retire_valid, flush, mem_valid, mem_ready, ld_hit, ld_stall;
  logic [31:0] st_addr, st_data, mem_addr, mem_data, ld_addr, ld_data;
  logic [3:0]  st_mask, mem_mask, ld_mask;

  store_buffer u_store_buffer (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  mask;
    logic        hit;
    logic        stall;
    logic [31:0] data;
  } lvec_t;

  // queue holds: 0x100/F/11223344, 0x104/3/AABBCCDD, 0x100/C/55667788, 0x108/F/01020304
  localparam lvec_t VEC [9] = '{
    '{32'h100, 4'hC, 1'b1, 1'b0, 32'h5566_0000},
    '{32'h100, 4'h3, 1'b1, 1'b0, 32'h0000_3344},
    '{32'h100, 4'hF, 1'b0, 1'b1, 32'h0},
    '{32'h104, 4'h1, 1'b1, 1'b0, 32'h0000_00DD},
    '{32'h104, 4'h4, 1'b0, 1'b0, 32'h0},
    '{32'h104, 4'h6, 1'b0, 1'b1, 32'h0},
    '{32'h108, 4'hF, 1'b1, 1'b0, 32'h0102_0304},
    '{32'h10C, 4'hF, 1'b0, 1'b0, 32'h0},
    '{32'h102, 4'h3, 1'b1, 1'b0, 32'h0000_3344}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
    st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
    tick;
    st_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic [3:0] m);
    ld_addr = a; ld_mask = m;
    #2;
  endtask

  initial begin
    rst_n = 0; st_valid = 0; st_addr = 0; st_data = 0; st_mask = 0;
    retire_valid = 0; flush = 0; mem_ready = 0; ld_addr = 0; ld_mask = 4'hF;
    repeat (3) tick;
    #2;
    chk("R1 st_full", st_full, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 ld_hit", ld_hit, 0);
    chk("R1 ld_stall", ld_stall, 0);
    rst_n = 1;
    tick;

    push(32'h100, 32'h1122_3344, 4'hF);
    push(32'h104, 32'hAABB_CCDD, 4'h3);
    push(32'h100, 32'h5566_7788, 4'hC);
    push(32'h108, 32'h0102_0304, 4'hF);
    #2 chk("R3 nothing retired", mem_valid, 0);

    // R6 full cover, R7 partial, R8 no overlap
    for (int i = 0; i < 9; i++) begin
      look(VEC[i].addr, VEC[i].mask);
      chk(VEC[i].hit ? "R6 hit" : (VEC[i].stall ? "R7 hit" : "R8 hit"), ld_hit, VEC[i].hit);
      chk(VEC[i].stall ? "R7 stall" : "R6 stall", ld_stall, VEC[i].stall);
      chk(VEC[i].hit ? "R6 data" : "R8 data", ld_data, VEC[i].data);
    end

    retire_valid = 1; tick; tick; retire_valid = 0;
    #2;
    chk("R3 mem_valid", mem_valid, 1);
    chk("R4 oldest addr", mem_addr, 32'h100);
    chk("R4 oldest data", mem_data, 32'h1122_3344);
    repeat (3) tick;
    #2 chk("R4 held addr", mem_addr, 32'h100);
    chk("R4 held mask", mem_mask, 4'hF);

    flush = 1; tick; flush = 0;
    look(32'h108, 4'hF); chk("R5 flushed miss", ld_hit, 0);
    look(32'h100, 4'hF); chk("R5 retired hit", ld_hit, 1);
    chk("R5 retired data", ld_data, 32'h1122_3344);

    retire_valid = 1; tick; retire_valid = 0;   // nothing speculative: ignored (R3)
    push(32'h200, 32'hCAFE_F00D, 4'hF);
    mem_ready = 1;
    #2 chk("R4 first drain", mem_addr, 32'h100);
    tick;
    #2 chk("R4 second valid", mem_valid, 1);
    chk("R4 second addr", mem_addr, 32'h104);
    chk("R4 second mask", mem_mask, 4'h3);
    tick;
    #2 chk("R3 spare retire ignored", mem_valid, 0);
    look(32'h104, 4'h1); chk("R9 drained no forward", ld_hit, 0);
    look(32'h200, 4'hF); chk("R9 speculative forward", ld_data, 32'hCAFE_F00D);
    retire_valid = 1; tick; retire_valid = 0;
    #2 chk("R3 retired offered", mem_addr, 32'h200);
    chk("R3 retired valid", mem_valid, 1);
    tick;
    #2 chk("R4 drained empty", mem_valid, 0);
    mem_ready = 0;

    for (int k = 0; k < 8; k++) push(32'h300 + 32'(4 * k), 32'hA000_0000 | 32'(k), 4'hF);
    #2 chk("R2 full", st_full, 1);
    push(32'h3FC, 32'hDEAD_BEEF, 4'hF);
    look(32'h3FC, 4'hF); chk("R2 dropped store", ld_hit, 0);
    look(32'h31C, 4'hF); chk("R2 youngest kept", ld_data, 32'hA000_0007);

    retire_valid = 1; flush = 1; tick; retire_valid = 0; flush = 0;
    #2 chk("R5 not full", st_full, 0);
    look(32'h300, 4'hF); chk("R5 retire beats flush", ld_data, 32'hA000_0000);
    look(32'h304, 4'hF); chk("R5 speculative gone", ld_hit, 0);
    chk("R5 survivor offered", mem_addr, 32'h300);

    st_valid = 1; st_addr = 32'h3F0; st_data = 32'h1234_5678; st_mask = 4'hF; flush = 1;
    tick; st_valid = 0; flush = 0;
    look(32'h3F0, 4'hF); chk("R5 store with flush dropped", ld_hit, 0);
    chk("R5 retired still offered", mem_valid, 1);
    mem_ready = 1; tick; mem_ready = 0;
    #2 chk("R4 final drain", mem_valid, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule